// File: doc/BRIEF.md
# Multi-Format Audio Serial Output Port

This block turns stereo 24-bit sample pairs into a three-wire audio stream: a bit clock, a word clock and a serial data line. The samples come either from a receiver, which delivers a left/right pair with a one-cycle strobe and flags for link errors and loss of lock, or from an auxiliary serial data input that runs on the same bit and word clocks. A 3-bit format code picks one of eight framings. Codes 0 to 5 are master framings: the block divides its system clock down to a 64-slot frame and drives both clocks. Codes 6 and 7 are slave framings: the bit and word clocks come in from outside, and the frame length follows whatever the word clock does.

Data is sent MSB first. It changes only on a falling bit-clock edge, and the auxiliary input is sampled on rising edges. A new pair is taken at the start of each left half-frame. Receive errors are handled at that point. A pair flagged with a link error never replaces the last good pair, so the last good data is sent again. While the receiver reports loss of lock, the receiver path sends zeros.

Top module: `aud_ser_out`

## Requirements
- R1: The format code is held in a register loaded from `fmt_wdata` when `fmt_we` is high. Its codes are 0=RJ16, 1=RJ18, 2=RJ20, 3=RJ24, 4=LJ24 master, 5=I2S master, 6=LJ24 slave, 7=I2S slave. Reset sets code 2 and drives `bclk_out`, `lrck_out` and `sdata_out` low.
- R2: In codes 0 to 5 the bit clock period is BCLK_DIV system clocks, and each half-frame holds exactly 32 bit slots.
- R3: Codes 0 to 3 are right-justified with 16, 18, 20 or 24 bits. Only the top bits of the 24-bit sample are sent, and the LSB occupies the last slot (31) of each half.
- R4: Code 4 is left-justified: sample bit 23 occupies slot 0 of each half.
- R5: In the I2S codes (5 and 7) bit 23 occupies slot 1 of each half, and the word clock is low during the left half.
- R6: In codes 0 to 4 and 6 the word clock is high during the left half. The word clock and the data line change only on a falling bit-clock edge.
- R7: In codes 6 and 7 `bclk_out` follows `bclk_in` three system clocks late. A change of `lrck_in` starts a new half (left when the level is the left level). A half may be longer than 32 slots, up to 64.
- R8: A strobed pair with `rx_err` high is discarded, so the last good pair is sent again.
- R9: While `rx_unlock` is high at the start of a frame and the receiver path is selected, that frame carries zeros in both halves.
- R10: With `src_aux` high, 24 bits per half are captured from `aux_din` on rising bit-clock edges. The capture is left-justified (first bit in slot 0), or I2S-aligned (slot 1) in codes 5 and 7. The data captured during one frame is sent in the next frame.
- R11: A receiver pair strobed during frame N is sent in frame N+1. The pair is latched on the falling edge that begins the left half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_we | input | 1 | Load strobe for the format code |
| fmt_wdata | input | 3 | Format code to load |
| src_aux | input | 1 | 1 selects the auxiliary serial input as data source |
| rx_valid | input | 1 | One-cycle strobe for a receiver sample pair |
| rx_left | input | 24 | Receiver left sample, two's complement |
| rx_right | input | 24 | Receiver right sample, two's complement |
| rx_err | input | 1 | Link error (parity, biphase or frame length) on the strobed pair |
| rx_unlock | input | 1 | Receiver not locked (level) |
| aux_din | input | 1 | Auxiliary serial data |
| bclk_in | input | 1 | External bit clock for the slave codes |
| lrck_in | input | 1 | External word clock for the slave codes |
| bclk_out | output | 1 | Bit clock in use |
| lrck_out | output | 1 | Word clock in use |
| sdata_out | output | 1 | Serial audio data |

## Verification
A receiver pair is applied right after the bench sees a frame begin, and it is due in the frame that follows. Auxiliary data set at the same point is due one frame later again, because it must first be captured over a whole frame. The bench tags each expected pair with the number of the frame that must carry it. The scoreboard decodes each finished frame from the bit and word clocks at the ports and compares it only against the entry whose tag matches, so each result is checked in the frame where it is due. In the slave codes every output edge trails the incoming clocks by the three-cycle synchronizer. The decoding counts slots from the word-clock edges at the outputs, so that delay does not move the check.

// File: rtl/aso_pkg.sv
package aso_pkg;

    localparam int SMP_W = 24;   // sample width
    localparam int MHALF = 32;   // bit slots per half in master codes
    localparam int POS_W = 7;    // slot counter width, covers slave halves

    typedef enum logic [2:0] {
        FMT_RJ16    = 3'd0,
        FMT_RJ18    = 3'd1,
        FMT_RJ20    = 3'd2,
        FMT_RJ24    = 3'd3,
        FMT_LJ      = 3'd4,
        FMT_I2S     = 3'd5,
        FMT_LJ_SLV  = 3'd6,
        FMT_I2S_SLV = 3'd7
    } fmt_e;

    localparam fmt_e FMT_DEF = FMT_RJ20;

    typedef struct packed {
        logic [SMP_W-1:0] l;
        logic [SMP_W-1:0] r;
    } pair_t;

    function automatic logic is_slave(logic [2:0] f);
        return f[2] & f[1];
    endfunction

    function automatic logic is_i2s(logic [2:0] f);
        return (f == FMT_I2S) || (f == FMT_I2S_SLV);
    endfunction

    function automatic int data_bits(logic [2:0] f);
        case (f)
            FMT_RJ16: return 16;
            FMT_RJ18: return 18;
            FMT_RJ20: return 20;
            default:  return SMP_W;
        endcase
    endfunction

    // slot of the MSB inside a half-frame
    function automatic int first_slot(logic [2:0] f);
        if (f < FMT_LJ) return MHALF - data_bits(f);
        return is_i2s(f) ? 1 : 0;
    endfunction

    // data bit driven in slot pos of a half carrying word w
    function automatic logic ser_bit(logic [2:0] f, logic [SMP_W-1:0] w,
                                     logic [POS_W-1:0] pos);
        int p, o, n;
        logic [4:0] k;
        p = int'(pos);
        o = first_slot(f);
        n = data_bits(f);
        if (p >= o && p < o + n) begin
            k = 5'(SMP_W - 1 - (p - o));
            return w[k];
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/aso_clkgen.sv
module aso_clkgen #(
    parameter int BCLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic slave,
    input  logic bclk_in,
    input  logic lrck_in,
    output logic rise_ev,
    output logic fall_ev,
    output logic bclk_o,
    output logic lrck_s
);
    localparam int HALF  = BCLK_DIV / 2;
    localparam int CNT_W = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic mb;
    logic s1, s2, s3, l1, l2;
    logic m_rise, m_fall;

    assign m_rise = (cnt == CNT_W'(HALF - 1));
    assign m_fall = (cnt == CNT_W'(BCLK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mb  <= 1'b0;
            s1  <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
            l1  <= 1'b0; l2 <= 1'b0;
        end else begin
            s1 <= bclk_in; s2 <= s1; s3 <= s2;
            l1 <= lrck_in; l2 <= l1;
            cnt <= m_fall ? '0 : cnt + 1'b1;
            if (m_rise)      mb <= 1'b1;
            else if (m_fall) mb <= 1'b0;
        end
    end

    assign rise_ev = slave ? (s2 & ~s3) : m_rise;
    assign fall_ev = slave ? (~s2 & s3) : m_fall;
    assign bclk_o  = slave ? s3 : mb;
    assign lrck_s  = l2;
endmodule

// File: rtl/aso_src.sv
module aso_src
    import aso_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       fmt,
    input  logic             rx_valid,
    input  logic [SMP_W-1:0] rx_left,
    input  logic [SMP_W-1:0] rx_right,
    input  logic             rx_err,
    input  logic             rx_unlock,
    input  logic             src_aux,
    input  logic             aux_din,
    input  logic             rise_ev,
    input  logic             chan,
    input  logic [POS_W-1:0] pos,
    output pair_t            pend
);
    pair_t good, acap;
    int    p, o;
    logic  in_win;
    logic [4:0] k;

    always_comb begin
        p      = int'(pos);
        o      = is_i2s(fmt) ? 1 : 0;
        in_win = (p >= o) && (p < o + SMP_W);
        k      = 5'(SMP_W - 1 - (p - o));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good <= '0;
            acap <= '0;
        end else begin
            if (rx_valid && !rx_err && !rx_unlock)
                good <= {rx_left, rx_right};
            if (rise_ev && in_win) begin
                if (chan) acap.r[k] <= aux_din;
                else      acap.l[k] <= aux_din;
            end
        end
    end

    assign pend = src_aux ? acap : (rx_unlock ? '0 : good);
endmodule

// File: rtl/aso_framer.sv
module aso_framer
    import aso_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       fmt,
    input  logic             fall_ev,
    input  logic             lrck_s,
    input  pair_t            pend,
    output logic             chan,
    output logic [POS_W-1:0] pos,
    output logic             start_ev,
    output pair_t            words,
    output logic             sdata,
    output logic             lrck_o
);
    logic             slv, left_lvl, lr_prev;
    logic             nchan, nstart;
    logic [POS_W-1:0] npos;
    logic [SMP_W-1:0] wsel;

    assign slv      = is_slave(fmt);
    assign left_lvl = ~is_i2s(fmt);

    always_comb begin
        nchan  = chan;
        npos   = pos;
        nstart = 1'b0;
        if (slv) begin
            if (lrck_s != lr_prev) begin
                nchan  = (lrck_s != left_lvl);
                npos   = '0;
                nstart = (lrck_s == left_lvl);
            end else if (pos != '1) begin
                npos = pos + 1'b1;
            end
        end else if (pos >= POS_W'(MHALF - 1)) begin
            npos   = '0;
            nchan  = ~chan;
            nstart = chan;
        end else begin
            npos = pos + 1'b1;
        end
        if (nstart)     wsel = pend.l;
        else if (nchan) wsel = words.r;
        else            wsel = words.l;
    end

    assign start_ev = fall_ev & nstart;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan    <= 1'b1;
            pos     <= POS_W'(MHALF - 1);
            lr_prev <= 1'b0;
            words   <= '0;
            sdata   <= 1'b0;
            lrck_o  <= 1'b0;
        end else if (fall_ev) begin
            chan    <= nchan;
            pos     <= npos;
            lr_prev <= lrck_s;
            if (nstart) words <= pend;
            sdata   <= ser_bit(fmt, wsel, npos);
            lrck_o  <= nchan ? ~left_lvl : left_lvl;
        end
    end
endmodule

// File: rtl/aud_ser_out.sv
module aud_ser_out
    import aso_pkg::*;
#(
    parameter int BCLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fmt_we,
    input  logic [2:0]  fmt_wdata,
    input  logic        src_aux,
    input  logic        rx_valid,
    input  logic [23:0] rx_left,
    input  logic [23:0] rx_right,
    input  logic        rx_err,
    input  logic        rx_unlock,
    input  logic        aux_din,
    input  logic        bclk_in,
    input  logic        lrck_in,
    output logic        bclk_out,
    output logic        lrck_out,
    output logic        sdata_out
);
    fmt_e             fmt_q;
    logic             rise_ev, fall_ev, lrck_s, chan, frm_start;
    logic [POS_W-1:0] pos;
    pair_t            pend, out_words;

    always_ff @(posedge clk) begin
        if (rst)         fmt_q <= FMT_DEF;
        else if (fmt_we) fmt_q <= fmt_e'(fmt_wdata);
    end

    aso_clkgen #(.BCLK_DIV(BCLK_DIV)) u_clk (
        .clk(clk), .rst(rst), .slave(is_slave(fmt_q)),
        .bclk_in(bclk_in), .lrck_in(lrck_in),
        .rise_ev(rise_ev), .fall_ev(fall_ev),
        .bclk_o(bclk_out), .lrck_s(lrck_s)
    );

    aso_src u_src (
        .clk(clk), .rst(rst), .fmt(fmt_q),
        .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right),
        .rx_err(rx_err), .rx_unlock(rx_unlock),
        .src_aux(src_aux), .aux_din(aux_din),
        .rise_ev(rise_ev), .chan(chan), .pos(pos), .pend(pend)
    );

    aso_framer u_frm (
        .clk(clk), .rst(rst), .fmt(fmt_q),
        .fall_ev(fall_ev), .lrck_s(lrck_s), .pend(pend),
        .chan(chan), .pos(pos), .start_ev(frm_start),
        .words(out_words), .sdata(sdata_out), .lrck_o(lrck_out)
    );
endmodule

// File: rtl/aud_ser_out_chk.sv
module aud_ser_out_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  fmt_q,
    input logic        bclk_in,
    input logic        bclk_out,
    input logic        lrck_out,
    input logic        sdata_out,
    input logic        rx_unlock,
    input logic        src_aux,
    input logic        frm_start,
    input logic [47:0] out_words
);
    AST_FMT_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> fmt_q == 3'd2); // R1

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdata_out) && $stable(fmt_q)) |-> $fell(bclk_out)); // R6

    AST_WCLK_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lrck_out) && $stable(fmt_q)) |-> $fell(bclk_out)); // R6

    AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (fmt_q[2:1] == 2'b11 && $past(fmt_q[2:1], 3) == 2'b11 &&
         !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
        |-> bclk_out == $past(bclk_in, 3)); // R7

    AST_UNLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (frm_start && rx_unlock && !src_aux) |=> out_words == 48'd0); // R9
endmodule

bind aud_ser_out aud_ser_out_chk u_chk (
    .clk(clk), .rst(rst), .fmt_q(fmt_q), .bclk_in(bclk_in),
    .bclk_out(bclk_out), .lrck_out(lrck_out), .sdata_out(sdata_out),
    .rx_unlock(rx_unlock), .src_aux(src_aux),
    .frm_start(frm_start), .out_words(out_words)
);

// File: tb/aud_ser_out_bench.sv
module aud_ser_out_bench;
    localparam int DIV = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        rst = 1'b1, fmt_we = 1'b0, src_aux = 1'b0, rx_valid = 1'b0;
    logic [2:0]  fmt_wdata = 3'd0;
    logic [23:0] rx_left = '0, rx_right = '0;
    logic        rx_err = 1'b0, rx_unlock = 1'b0, aux_din = 1'b0;
    logic        bclk_in = 1'b0, lrck_in = 1'b0;
    logic        bclk_out, lrck_out, sdata_out;

    aud_ser_out #(.BCLK_DIV(DIV)) u_aud_ser_out (
        .clk(clk), .rst(rst), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata),
        .src_aux(src_aux), .rx_valid(rx_valid), .rx_left(rx_left),
        .rx_right(rx_right), .rx_err(rx_err), .rx_unlock(rx_unlock),
        .aux_din(aux_din), .bclk_in(bclk_in), .lrck_in(lrck_in),
        .bclk_out(bclk_out), .lrck_out(lrck_out), .sdata_out(sdata_out)
    );

    typedef struct {
        int          tag;
        logic [23:0] l;
        logic [23:0] r;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          n_cmp = 0, n_bad = 0, frame_no = 0;
    logic [2:0]  mfmt = 3'd2;
    logic        slv_on = 1'b0;
    logic [23:0] aux_l = '0, aux_r = '0;

    function automatic int b_len(logic [2:0] f);
        if (f == 3'd0) return 16;
        if (f == 3'd1) return 18;
        if (f == 3'd2) return 20;
        return 24;
    endfunction
    function automatic int b_off(logic [2:0] f);
        if (f <= 3'd3) return 32 - b_len(f);
        return (f == 3'd5 || f == 3'd7) ? 1 : 0;
    endfunction
    function automatic logic b_left(logic [2:0] f);
        return !(f == 3'd5 || f == 3'd7);
    endfunction

    task automatic chk(bit ok, string req, logic [47:0] act, logic [47:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- monitor / scoreboard ----------------
    logic lb[128], rb[128];
    int   ln = 0, rn = 0, aslot = 0;
    logic pb = 1'b0, plr = 1'b0, in_frame = 1'b0;

    task automatic decode(int fno);
        int o, n;
        logic [23:0] gl, gr, el, er;
        if (q.size() == 0 || q[0].tag > fno) return;
        o = b_off(mfmt);
        n = b_len(mfmt);
        gl = '0; gr = '0;
        for (int k = 0; k < n; k++) begin
            gl = {gl[22:0], lb[o+k]};
            gr = {gr[22:0], rb[o+k]};
        end
        el = q[0].l >> (24 - n);
        er = q[0].r >> (24 - n);
        if (mfmt < 3'd6)
            chk(ln == 32 && rn == 32, "R2 slots per half",
                48'(ln * 256 + rn), 48'(32 * 256 + 32));
        chk(gl == el && gr == er, q[0].req, {gl, gr}, {el, er});
        q.delete(0);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (bclk_out && !pb) begin
                if (lrck_out != plr && lrck_out == b_left(mfmt)) begin
                    if (in_frame) decode(frame_no);
                    frame_no++;
                    in_frame = 1'b1;
                    ln = 0; rn = 0;
                end
                if (lrck_out == b_left(mfmt)) begin
                    if (ln < 128) begin lb[ln] = sdata_out; ln++; end
                end else begin
                    if (rn < 128) begin rb[rn] = sdata_out; rn++; end
                end
                plr = lrck_out;
            end
            if (!bclk_out && pb) begin
                int ao;
                logic [23:0] aw;
                aslot = (lrck_out != plr) ? 0 : aslot + 1;
                ao = (mfmt == 3'd5 || mfmt == 3'd7) ? 1 : 0;
                aw = (lrck_out == b_left(mfmt)) ? aux_l : aux_r;
                if (aslot >= ao && aslot < ao + 24) aux_din = aw[23 - (aslot - ao)];
                else aux_din = 1'b0;
            end
            pb = bclk_out;
        end
    end

    // ---------------- slave clock source (128 slots per frame) ----------------
    initial begin
        forever begin
            if (slv_on) begin
                for (int h = 0; h < 2; h++) begin
                    for (int b = 0; b < 64; b++) begin
                        @(negedge clk);
                        bclk_in = 1'b0;
                        if (b == 0) lrck_in = (h == 0) ? b_left(mfmt) : !b_left(mfmt);
                        repeat (7) @(negedge clk);
                        bclk_in = 1'b1;
                        repeat (7) @(negedge clk);
                    end
                end
            end else begin
                @(negedge clk);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic wait_frame();
        int f = frame_no;
        while (frame_no == f) @(negedge clk);
    endtask

    task automatic set_fmt(logic [2:0] f);
        @(negedge clk);
        fmt_we = 1'b1; fmt_wdata = f;
        @(negedge clk);
        fmt_we = 1'b0;
        mfmt = f;
        wait_frame();
        wait_frame();
    endtask

    task automatic send(logic [23:0] l, logic [23:0] r, logic err, logic unl,
                        logic [23:0] el, logic [23:0] er, string req);
        wait_frame();
        rx_left = l; rx_right = r; rx_err = err; rx_unlock = unl;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        q.push_back('{frame_no + 1, el, er, req});
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic aux_case(logic [23:0] l, logic [23:0] r, string req);
        wait_frame();
        aux_l = l; aux_r = r;
        q.push_back('{frame_no + 2, l, r, req});
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk({bclk_out, lrck_out, sdata_out} == 3'b000, "R1 outputs in reset",
            48'({bclk_out, lrck_out, sdata_out}), 48'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({lrck_out, sdata_out} == 2'b00, "R1 outputs after reset",
            48'({lrck_out, sdata_out}), 48'd0);
        begin
            int n = 0;
            while (!(bclk_out && !pb)) @(negedge clk);
            @(negedge clk); n = 1;
            while (!(bclk_out && !pb)) begin @(negedge clk); n++; end
            chk(n == DIV, "R2 bit clock period", 48'(n), 48'(DIV));
        end

        send(24'hA5C3E1, 24'h3C5A96, 0, 0, 24'hA5C3E1, 24'h3C5A96, "R1 R3 R11 default code 2");
        set_fmt(3'd0);
        send(24'h81F00F, 24'h7E0FF0, 0, 0, 24'h81F00F, 24'h7E0FF0, "R3 RJ16");
        set_fmt(3'd1);
        send(24'hC0FFEE, 24'h123457, 0, 0, 24'hC0FFEE, 24'h123457, "R3 RJ18");
        set_fmt(3'd3);
        send(24'h800001, 24'h7FFFFE, 0, 0, 24'h800001, 24'h7FFFFE, "R3 RJ24 LSB in slot 31");
        set_fmt(3'd4);
        send(24'hF0E1D2, 24'h0F1E2D, 0, 0, 24'hF0E1D2, 24'h0F1E2D, "R4 R6 LJ24");
        set_fmt(3'd5);
        send(24'h9ABCDE, 24'h654321, 0, 0, 24'h9ABCDE, 24'h654321, "R5 I2S master");
        set_fmt(3'd4);
        send(24'h111111, 24'h222222, 0, 0, 24'h111111, 24'h222222, "R11 good pair");
        send(24'h333333, 24'h444444, 1, 0, 24'h111111, 24'h222222, "R8 error repeats last good");
        send(24'h555555, 24'h666666, 0, 1, 24'h000000, 24'h000000, "R9 unlock sends zeros");
        send(24'h777777, 24'h888888, 0, 0, 24'h777777, 24'h888888, "R9 R11 relock");

        src_aux = 1'b1;
        aux_case(24'hB4D2F0, 24'h4B2D0F, "R10 aux left-justified");
        set_fmt(3'd5);
        aux_case(24'hE7C3A5, 24'h183C5A, "R10 aux I2S");
        src_aux = 1'b0;

        slv_on = 1'b1;
        set_fmt(3'd6);
        send(24'hDEAD01, 24'hBEEF02, 0, 0, 24'hDEAD01, 24'hBEEF02, "R7 R6 slave LJ 128fs");
        set_fmt(3'd7);
        send(24'h13579B, 24'h2468AC, 0, 0, 24'h13579B, 24'h2468AC, "R7 R5 slave I2S 128fs");

        finish_run();
    end
endmodule